// File: doc/BRIEF.md
# Vector Compare-to-Predicate Unit

This unit turns a compact conditional-branch style instruction that names vectorised operands into an element-wise comparison. It does not redirect control flow. Each element pair is compared, and the result (1 when the condition holds, 0 when it does not) is written into the bit of a predicate word that matches the element's index. The surrounding datapath reads the named predicate register and presents its current contents as the starting word. It then serves one element pair per cycle at the index the unit requests. When the unit signals completion, the datapath writes the final word back to the register whose number travelled in the instruction's former offset field.

The instruction selects integer or single-precision floating-point operands and one of four comparators: EQ, NE, LT and LE. A separate reverse flag swaps the two operands, so LT becomes GT and LE becomes GE. An incoming lane mask protects individual bits of the word. Bits at or above the vector length are never touched. Floating-point comparisons are ordered compares of finite IEEE single values only.

Top module: `vcp_unit`

## Requirements
- R1: An instruction is accepted only when bits [1:0] equal 01 and bits [15:14] equal 11. Any other word pulses `bad_op` for one cycle after the start cycle. The unit stays idle and `pred_word` keeps its value.
- R2: The operator is picked by bit 13 (the low bit of the 3-bit function field in [15:13]) together with bit 5. Bit 13 = 0 with bit 5 = 0 gives EQ. Bit 13 = 0 with bit 5 = 1 gives NE. Bit 13 = 1 with bit 5 = 0 gives LT. Bit 13 = 1 with bit 5 = 1 gives LE.
- R3: When bit 6 is 0, operands are 32-bit two's-complement integers, and LT/LE are signed.
- R4: When bit 6 is 1, operands are IEEE single values compared in ordered fashion, and +0 equals -0.
- R5: When `rev` is high at the start cycle, elem_b is the left operand and elem_a the right operand, which turns LT into GT and LE into GE.
- R6: Elements are processed one per cycle in ascending order. During the k-th busy cycle `elem_idx` equals k. The result for element k appears in `pred_word[k]` after the clock edge that ends that cycle.
- R7: `pred_word` is loaded from `pred_init` at the accepted start. Bits at or above the effective vector length keep their loaded value. A `vl` above 32 counts as 32. A `vl` of 0 completes with no busy cycle.
- R8: A lane whose `in_mask` bit (captured at start) is 0 keeps its loaded bit.
- R9: `done` is a one-cycle pulse in the cycle right after the final element's edge, which is also the cycle in which `busy` drops.
- R10: `pred_dst` carries instruction bits [12:10] captured at the accepted start.
- R11: A `start` pulse while `busy` is high is ignored, and the running operation completes unchanged.
- R12: During reset `busy`, `done`, `bad_op`, `pred_dst` and `pred_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| instr | input | 16 | Compact compare instruction word |
| rev | input | 1 | Swap operands (GT/GE) |
| vl | input | 6 | Vector length, clamped to 32 |
| in_mask | input | 32 | Lanes allowed to be written |
| pred_init | input | 32 | Current contents of the target predicate register |
| elem_a | input | 32 | First source element at `elem_idx` |
| elem_b | input | 32 | Second source element at `elem_idx` |
| busy | output | 1 | Comparison in progress |
| elem_idx | output | 5 | Element index requested this cycle |
| pred_dst | output | 3 | Target predicate register number |
| pred_word | output | 32 | Predicate word being built |
| done | output | 1 | One-cycle completion pulse |
| bad_op | output | 1 | One-cycle pulse for an unsupported instruction |

## Verification
A start sampled at edge E raises `busy` in the cycle after E. Element k's bit lands at edge E+k+1. `done` and the fall of `busy` follow the edge E+vl, and both `bad_op` and a zero-length `done` appear one cycle after E. The bench model advances on the same rising edges and keeps the same register count, so every output is expected in exactly the cycle named above. All outputs are compared on the falling edge of every cycle, which keeps each sample half a period away from the edge where the value changes.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  localparam int unsigned EW = 32;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_LE = 2'd3
  } cmp_op_e;

  typedef struct packed {
    logic       legal;
    cmp_op_e    op;
    logic       is_fp;
    logic [2:0] dst;
  } dec_t;

  function automatic logic fp_is_zero(input logic [EW-1:0] x);
    return (x[EW-2:0] == '0);
  endfunction

  function automatic logic fp_eq(input logic [EW-1:0] a, input logic [EW-1:0] b);
    return (fp_is_zero(a) && fp_is_zero(b)) || (a == b);
  endfunction

  // ordered less-than on finite single values, signed zeros equal
  function automatic logic fp_lt(input logic [EW-1:0] a, input logic [EW-1:0] b);
    logic r;
    if (fp_is_zero(a) && fp_is_zero(b))
      r = 1'b0;
    else if (a[EW-1] != b[EW-1])
      r = a[EW-1];
    else if (!a[EW-1])
      r = (a[EW-2:0] < b[EW-2:0]);
    else
      r = (a[EW-2:0] > b[EW-2:0]);
    return r;
  endfunction

  function automatic logic int_lt(input logic [EW-1:0] a, input logic [EW-1:0] b);
    return ($signed(a) < $signed(b));
  endfunction

  function automatic logic cmp_eval(input cmp_op_e op, input logic is_fp,
                                    input logic [EW-1:0] a, input logic [EW-1:0] b);
    logic eq;
    logic lt;
    eq = is_fp ? fp_eq(a, b) : (a == b);
    lt = is_fp ? fp_lt(a, b) : int_lt(a, b);
    case (op)
      CMP_EQ:  return eq;
      CMP_NE:  return !eq;
      CMP_LT:  return lt;
      default: return lt | eq;
    endcase
  endfunction

endpackage

// File: rtl/vcp_decode.sv
module vcp_decode
  import vcp_pkg::*;
(
  input  logic [15:0] instr,
  output dec_t        dec
);

  logic quad_ok;
  logic func_ok;
  logic unused_fields;

  assign quad_ok       = (instr[1:0] == 2'b01);
  assign func_ok       = (instr[15:14] == 2'b11);
  assign unused_fields = ^{instr[9:7], instr[4:2]};

  always_comb begin
    dec.legal = quad_ok & func_ok;
    dec.op    = cmp_op_e'({instr[13], instr[5]});
    dec.is_fp = instr[6];
    dec.dst   = instr[12:10];
  end

endmodule

// File: rtl/vcp_cmp.sv
module vcp_cmp
  import vcp_pkg::*;
(
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          rev,
  input  cmp_op_e       op,
  input  logic          is_fp,
  output logic          hit
);

  logic [EW-1:0] lhs;
  logic [EW-1:0] rhs;

  always_comb begin
    lhs = rev ? b : a;
    rhs = rev ? a : b;
    hit = cmp_eval(op, is_fp, lhs, rhs);
  end

endmodule

// File: rtl/vcp_seq.sv
module vcp_seq #(
  parameter int unsigned LANES = 32,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VL_W  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legal,
  input  logic [VL_W-1:0]  vl,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             load,
  output logic             is_last,
  output logic             done,
  output logic             bad_op
);

  logic             busy_q;
  logic             done_q;
  logic             bad_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [VL_W-1:0]  vl_eff;
  logic             accept;

  assign vl_eff  = (vl > VL_W'(LANES)) ? VL_W'(LANES) : vl;
  assign accept  = start & ~busy_q;
  assign load    = accept & legal;
  assign is_last = busy_q && (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      if (busy_q) begin
        if (is_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end else if (accept) begin
        if (!legal) begin
          bad_q <= 1'b1;
        end else if (vl_eff == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          last_q <= IDX_W'(vl_eff - VL_W'(1));
        end
      end
    end
  end

  assign busy   = busy_q;
  assign idx    = idx_q;
  assign done   = done_q;
  assign bad_op = bad_q;

  // R1
  illegal_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_q && !legal |=> bad_q && !busy_q);

  // R6
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !is_last |=> busy_q && (idx_q == $past(idx_q) + IDX_W'(1)));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && (vl == '0) |=> done_q && !busy_q);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_last |=> done_q && !busy_q);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/vcp_pword.sv
module vcp_pword #(
  parameter int unsigned LANES = 32,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] init,
  input  logic             step,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] mask,
  input  logic             hit,
  output logic [LANES-1:0] word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic bit_q;
    logic wr;

    assign wr = step && (idx == IDX_W'(g)) && mask[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (load)
        bit_q <= init[g];
      else if (wr)
        bit_q <= hit;
    end

    assign word[g] = bit_q;
  end

endmodule

// File: rtl/vcp_unit.sv
module vcp_unit
  import vcp_pkg::*;
#(
  parameter int unsigned LANES = 32,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VL_W  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      instr,
  input  logic             rev,
  input  logic [VL_W-1:0]  vl,
  input  logic [LANES-1:0] in_mask,
  input  logic [LANES-1:0] pred_init,
  input  logic [EW-1:0]    elem_a,
  input  logic [EW-1:0]    elem_b,
  output logic             busy,
  output logic [IDX_W-1:0] elem_idx,
  output logic [2:0]       pred_dst,
  output logic [LANES-1:0] pred_word,
  output logic             done,
  output logic             bad_op
);

  dec_t             dec;
  logic             load;
  logic             is_last;
  logic             hit;
  cmp_op_e          op_q;
  logic             fp_q;
  logic             rev_q;
  logic [2:0]       dst_q;
  logic [LANES-1:0] mask_q;

  vcp_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  vcp_seq #(.LANES(LANES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .legal   (dec.legal),
    .vl      (vl),
    .busy    (busy),
    .idx     (elem_idx),
    .load    (load),
    .is_last (is_last),
    .done    (done),
    .bad_op  (bad_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= CMP_EQ;
      fp_q   <= 1'b0;
      rev_q  <= 1'b0;
      dst_q  <= '0;
      mask_q <= '0;
    end else if (load) begin
      op_q   <= dec.op;
      fp_q   <= dec.is_fp;
      rev_q  <= rev;
      dst_q  <= dec.dst;
      mask_q <= in_mask;
    end
  end

  vcp_cmp u_cmp (
    .a     (elem_a),
    .b     (elem_b),
    .rev   (rev_q),
    .op    (op_q),
    .is_fp (fp_q),
    .hit   (hit)
  );

  vcp_pword #(.LANES(LANES)) u_pw (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .init  (pred_init),
    .step  (busy),
    .idx   (elem_idx),
    .mask  (mask_q),
    .hit   (hit),
    .word  (pred_word)
  );

  assign pred_dst = dst_q;

  // R8
  masked_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mask_q[elem_idx] |=> pred_word == $past(pred_word));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> pred_dst == $past(pred_dst));

  // R7
  idle_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !load |=> pred_word == $past(pred_word));

  // R6
  one_bit_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones(pred_word ^ $past(pred_word)) <= 1);

endmodule

// File: tb/tb_vcp_unit.sv
`timescale 1ns/1ps
module tb_vcp_unit;

  localparam int LANES = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] instr;
  logic        rev;
  logic [5:0]  vl;
  logic [31:0] in_mask;
  logic [31:0] pred_init;
  logic [31:0] elem_a;
  logic [31:0] elem_b;
  logic        busy;
  logic [4:0]  elem_idx;
  logic [2:0]  pred_dst;
  logic [31:0] pred_word;
  logic        done;
  logic        bad_op;

  always #2.5 clk = ~clk;

  vcp_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .rev(rev), .vl(vl),
    .in_mask(in_mask), .pred_init(pred_init), .elem_a(elem_a), .elem_b(elem_b),
    .busy(busy), .elem_idx(elem_idx), .pred_dst(pred_dst), .pred_word(pred_word),
    .done(done), .bad_op(bad_op)
  );

  logic [31:0] va [LANES];
  logic [31:0] vb [LANES];
  assign elem_a = va[elem_idx];
  assign elem_b = vb[elem_idx];

  int    tests = 0;
  int    fails = 0;
  int    cyc   = 0;
  bit    checking = 0;
  string tag = "R12";

  // behavioural model state
  bit        m_busy, m_done, m_bad, m_fp, m_rev;
  int        m_idx, m_last, m_kind;
  bit [31:0] m_word, m_mask;
  bit [2:0]  m_dst;

  function automatic logic [31:0] okey(logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  // kind: 0 EQ, 1 NE, 2 LT, 3 LE
  function automatic bit ref_cmp(int kind, bit fp, bit r, logic [31:0] x, logic [31:0] y);
    logic [31:0] p, q;
    bit lt, eq;
    p = r ? y : x;
    q = r ? x : y;
    if (fp) begin
      lt = okey(p) < okey(q);
      eq = okey(p) == okey(q);
    end else begin
      lt = $signed(p) < $signed(q);
      eq = p == q;
    end
    case (kind)
      0: return eq;
      1: return !eq;
      2: return lt;
      default: return lt || eq;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_bad = 0; m_idx = 0; m_last = 0;
      m_word = 0; m_mask = 0; m_dst = 0; m_fp = 0; m_rev = 0; m_kind = 0;
    end else begin
      m_done = 0;
      m_bad  = 0;
      if (m_busy) begin
        if (m_mask[m_idx]) m_word[m_idx] = ref_cmp(m_kind, m_fp, m_rev, va[m_idx], vb[m_idx]);
        if (m_idx == m_last) begin
          m_busy = 0;
          m_done = 1;
        end else begin
          m_idx++;
        end
      end else if (start) begin
        if (instr[1:0] != 2'b01 || instr[15:14] != 2'b11) begin
          m_bad = 1;
        end else begin
          int n;
          m_kind = int'({instr[13], instr[5]});
          m_fp   = instr[6];
          m_rev  = rev;
          m_dst  = instr[12:10];
          m_mask = in_mask;
          m_word = pred_init;
          n = (vl > 32) ? 32 : int'(vl);
          if (n == 0) m_done = 1;
          else begin
            m_busy = 1;
            m_idx  = 0;
            m_last = n - 1;
          end
        end
      end
    end
  end

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk("R9", "busy", 32'(busy), 32'(m_busy));
      chk("R9", "done", 32'(done), 32'(m_done));
      chk("R1", "bad_op", 32'(bad_op), 32'(m_bad));
      chk(tag, "pred_word", pred_word, m_word);
      if (m_busy) chk("R6", "elem_idx", 32'(elem_idx), 32'(m_idx));
      if (m_done) chk("R10", "pred_dst", 32'(pred_dst), 32'(m_dst));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [15:0] mk(logic [2:0] f3, logic [2:0] d, logic fp, logic b);
    return {f3, d, 3'b000, fp, b, 3'b000, 2'b01};
  endfunction

  function automatic logic [31:0] fpat(int n);
    case (n % 8)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h3F80_0000;
      3: return 32'hBF80_0000;
      4: return 32'h4020_0000;
      5: return 32'hC020_0000;
      6: return 32'h0000_0010;
      default: return 32'h7F00_0000;
    endcase
  endfunction

  task automatic fill_int;
    for (int k = 0; k < LANES; k++) begin
      va[k] = 32'(k * 3 - 40);
      vb[k] = (k % 4 == 0) ? va[k] : 32'(20 - k * 2);
    end
  endtask

  task automatic fill_fp;
    for (int k = 0; k < LANES; k++) begin
      va[k] = fpat(k);
      vb[k] = (k % 7 == 3) ? fpat(k) : fpat(k * 3 + 1);
    end
  endtask

  task automatic pulse(logic [15:0] i, logic r, int n, logic [31:0] m, logic [31:0] init);
    @(negedge clk);
    instr = i; rev = r; vl = 6'(n); in_mask = m; pred_init = init; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle;
    do @(negedge clk); while (m_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(string t, logic [15:0] i, logic r, int n, logic [31:0] m, logic [31:0] init);
    tag = t;
    pulse(i, r, n, m, init);
    settle();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0; rev = 1'b0; vl = '0;
    in_mask = '0; pred_init = '0;
    fill_int();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "busy", 32'(busy), 0);
    chk("R12", "done", 32'(done), 0);
    chk("R12", "bad_op", 32'(bad_op), 0);
    chk("R12", "pred_dst", 32'(pred_dst), 0);
    chk("R12", "pred_word", pred_word, 0);
    rst_n = 1'b1;
    checking = 1;
    @(negedge clk);

    // R2 / R3 integer operators
    run("R2", mk(3'b110, 3'd1, 1'b0, 1'b0), 1'b0, 8,  32'hFFFF_FFFF, 32'h0);
    run("R2", mk(3'b110, 3'd2, 1'b0, 1'b1), 1'b0, 12, 32'hFFFF_FFFF, 32'hFFFF_0000);
    run("R3", mk(3'b111, 3'd3, 1'b0, 1'b0), 1'b0, 20, 32'hFFFF_FFFF, 32'h0);
    run("R3", mk(3'b111, 3'd4, 1'b0, 1'b1), 1'b0, 20, 32'hFFFF_FFFF, 32'h0);
    // R5 reversed integer (GT, GE)
    run("R5", mk(3'b111, 3'd5, 1'b0, 1'b0), 1'b1, 32, 32'hFFFF_FFFF, 32'h0);
    run("R5", mk(3'b111, 3'd6, 1'b0, 1'b1), 1'b1, 32, 32'hFFFF_FFFF, 32'h0);
    // R8 partial mask
    run("R8", mk(3'b111, 3'd7, 1'b0, 1'b0), 1'b0, 32, 32'h0F0F_3C5A, 32'h1234_5678);
    // R7 length corner cases
    run("R7", mk(3'b111, 3'd1, 1'b0, 1'b0), 1'b0, 0,  32'hFFFF_FFFF, 32'hA5A5_A5A5);
    run("R7", mk(3'b111, 3'd2, 1'b0, 1'b1), 1'b0, 40, 32'hFFFF_FFFF, 32'h0);
    run("R7", mk(3'b110, 3'd3, 1'b0, 1'b1), 1'b0, 5,  32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R4 floating point
    fill_fp();
    run("R4", mk(3'b111, 3'd5, 1'b1, 1'b0), 1'b0, 32, 32'hFFFF_FFFF, 32'h0);
    run("R4", mk(3'b110, 3'd5, 1'b1, 1'b0), 1'b0, 16, 32'hFFFF_FFFF, 32'h0);
    run("R4", mk(3'b111, 3'd6, 1'b1, 1'b1), 1'b0, 24, 32'hFFFF_FFFF, 32'h0);
    run("R5", mk(3'b111, 3'd0, 1'b1, 1'b1), 1'b1, 32, 32'hFFFF_FFFF, 32'h0);

    // R1 illegal encodings leave the word alone
    run("R1", 16'h0001, 1'b0, 8, 32'hFFFF_FFFF, 32'h5555_5555);
    run("R1", {3'b110, 3'd2, 8'h00, 2'b10}, 1'b0, 8, 32'hFFFF_FFFF, 32'h5555_5555);

    // R11 start during busy is ignored
    fill_int();
    tag = "R11";
    pulse(mk(3'b111, 3'd4, 1'b0, 1'b0), 1'b0, 10, 32'hFFFF_FFFF, 32'h0);
    @(negedge clk);
    pulse(mk(3'b110, 3'd7, 1'b0, 1'b1), 1'b1, 3, 32'h0000_00FF, 32'hFFFF_FFFF);
    settle();

    // R10 destination field on its own
    run("R10", mk(3'b110, 3'd7, 1'b0, 1'b0), 1'b0, 4, 32'hFFFF_FFFF, 32'h0);

    checking = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule